// File: doc/BRIEF.md
# Long-Press Supervisory Reset Controller

This block drives an active-low system reset from two kinds of request. Digital supply-good flags arrive from external comparators. A drop on any of them pulls the reset low at once, and the reset stays low for a fixed hold time after every flag is high again. Active-low pushbuttons arrive as the second source. A button counts only after it has been held down without a break for a long setup time. A valid press then produces exactly one reset pulse of the hold length, even if the button stays down.

A parameter selects single-button or dual-button operation. In dual mode both buttons must be held together for the whole setup time. After a pulse, the block re-arms only once a button has been released. All inputs pass through a two-flop synchronizer. The setup and hold lengths are parameters counted in clock cycles, so a bench can run with short values.

Top module: `lpress_reset_ctrl`

## Requirements
- R1: A low level on any bit of `supply_ok_i` drives `sys_rst_n_o` low by the third rising clock edge after the input change.
- R2: Once every supply flag is high again, `sys_rst_n_o` returns high HOLD_CYC+2 rising edges after the last flag rose. A supply drop of F cycles therefore keeps the output low for F+HOLD_CYC-1 cycles.
- R3: A press that stays low for at least SETUP_CYC consecutive cycles drives `sys_rst_n_o` low SETUP_CYC+2 rising edges after the press began. In single mode the press is bit 0 of `btn_n_i` at 0. In dual mode it is both bits at 0.
- R4: A press shorter than SETUP_CYC cycles leaves `sys_rst_n_o` high.
- R5: A valid press gives exactly one low pulse of HOLD_CYC cycles, however long the button is held.
- R6: After a pulse, a release of at least one cycle followed by a new full-length press gives a second pulse.
- R7: In dual mode, the count runs only while both buttons are low. Releasing either button restarts the count from zero.
- R8: In single mode, bit 1 of `btn_n_i` has no effect on `sys_rst_n_o`.
- R9: A supply drop during a manual pulse keeps the output low until the supply hold time ends. This is measured from the supply recovery, as in R2. The press that caused the pulse stays consumed and produces no further pulse while it is held.
- R10: While `rst_n` is low, `sys_rst_n_o` is low. After `rst_n` rises with all supplies good, the output goes high HOLD_CYC+2 rising edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; all timing counts its rising edges |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the controller |
| supply_ok_i | input | NUM_SUPPLY | Asynchronous supply-good flags, high when the supply is in range |
| btn_n_i | input | 2 | Asynchronous active-low pushbuttons; bit 1 is used only in dual mode |
| sys_rst_n_o | output | 1 | Registered active-low system reset |

## Verification
The state that matters here is small: the setup count, the arm flag and the hold count. Errors in each show up at the reset pin in a distinct way.

A setup count that is off by one moves the start of the pulse by one cycle, or lets a press one cycle too short through. Sweeping the press length across the threshold shows this on the first run.

An arm flag that fails to clear gives a second pulse from a press that is still held. An arm flag that fails to set hides the pulse after a release. Both show as a wrong count of falling edges within one press window.

A hold counter with the wrong limit, or one that is not restarted by a supply drop, changes the number of low cycles. This is visible as soon as the pulse ends.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

  // counter width able to hold values 0 .. limit-1
  function automatic int cnt_bits(input int limit);
    return (limit <= 2) ? 1 : $clog2(limit);
  endfunction

  // press condition from synchronized active-low buttons
  function automatic logic press_seen(input logic [1:0] btn_lvl, input bit dual);
    return dual ? (btn_lvl == 2'b00) : !btn_lvl[0];
  endfunction

endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= {W{RST_VAL}};
      q    <= {W{RST_VAL}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lpr_press_det.sv
module lpr_press_det
  import lpr_pkg::*;
#(
  parameter int SETUP_CYC = 8,
  parameter bit DUAL_BTN  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] btn_s,
  output logic       pressed,
  output logic       armed,
  output logic       fire
);
  localparam int             CW   = cnt_bits(SETUP_CYC);
  localparam logic [CW-1:0]  LAST = CW'(SETUP_CYC - 1);

  logic [CW-1:0] cnt;

  assign pressed = press_seen(btn_s, DUAL_BTN);
  assign fire    = pressed && armed && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (!pressed) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (armed) begin
      if (cnt == LAST) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R4
  fire_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (SETUP_CYC < 2) || $past(pressed));

  // R5
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

  // R6
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pressed) |-> armed);

  // R7
  dual_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (!DUAL_BTN) || (btn_s == 2'b00));
endmodule

// File: rtl/lpr_hold_timer.sv
module lpr_hold_timer
  import lpr_pkg::*;
#(
  parameter int HOLD_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic fire,
  output logic rst_q
);
  localparam int            CW   = cnt_bits(HOLD_CYC);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b1;
      tmr   <= '0;
    end else if (fault || fire) begin
      rst_q <= 1'b1;
      tmr   <= '0;
    end else if (rst_q) begin
      if (tmr == LAST) begin
        rst_q <= 1'b0;
        tmr   <= '0;
      end else begin
        tmr <= tmr + CW'(1);
      end
    end
  end

  // R5
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> ($past(tmr) == LAST));
endmodule

// File: rtl/lpress_reset_ctrl.sv
module lpress_reset_ctrl #(
  parameter int NUM_SUPPLY = 2,
  parameter bit DUAL_BTN   = 1'b1,
  parameter int SETUP_CYC  = 672_000_000,
  parameter int HOLD_CYC   = 21_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SUPPLY-1:0] supply_ok_i,
  input  logic [1:0]            btn_n_i,
  output logic                  sys_rst_n_o
);
  logic [NUM_SUPPLY-1:0] sup_s;
  logic [1:0]            btn_s;
  logic                  supplies_good;
  logic                  fault;
  logic                  pressed;
  logic                  armed;
  logic                  fire;
  logic                  rst_q;

  for (genvar g = 0; g < NUM_SUPPLY; g++) begin : g_sup
    lpr_sync #(.W(1), .RST_VAL(1'b0)) u_sup_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (supply_ok_i[g]),
      .q     (sup_s[g])
    );
  end

  lpr_sync #(.W(2), .RST_VAL(1'b1)) u_btn_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (btn_n_i),
    .q     (btn_s)
  );

  assign supplies_good = &sup_s;
  assign fault         = !supplies_good;

  lpr_press_det #(.SETUP_CYC(SETUP_CYC), .DUAL_BTN(DUAL_BTN)) u_press (
    .clk     (clk),
    .rst_n   (rst_n),
    .btn_s   (btn_s),
    .pressed (pressed),
    .armed   (armed),
    .fire    (fire)
  );

  lpr_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .fault (fault),
    .fire  (fire),
    .rst_q (rst_q)
  );

  assign sys_rst_n_o = !rst_q;

  // R1
  supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !sys_rst_n_o);

  // R2
  release_needs_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n_o) |-> $past(supplies_good));

  // R3
  fire_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !sys_rst_n_o);
endmodule

// File: tb/lpress_reset_ctrl_bench.sv
module lpress_reset_ctrl_bench;
  localparam int S  = 8;
  localparam int H  = 5;
  localparam int NW = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic [1:0] sup;
  logic [1:0] btn;
  logic       out_d;
  logic       out_s;

  lpress_reset_ctrl #(.NUM_SUPPLY(2), .DUAL_BTN(1'b1), .SETUP_CYC(S), .HOLD_CYC(H))
    u_lpress_reset_ctrl (.clk(clk), .rst_n(rst_n), .supply_ok_i(sup),
                         .btn_n_i(btn), .sys_rst_n_o(out_d));

  lpress_reset_ctrl #(.NUM_SUPPLY(2), .DUAL_BTN(1'b0), .SETUP_CYC(S), .HOLD_CYC(H))
    u_single (.clk(clk), .rst_n(rst_n), .supply_ok_i(sup),
              .btn_n_i(btn), .sys_rst_n_o(out_s));

  int vectors = 0;
  int miscompares = 0;
  int wd = 0;

  logic [1:0] pb [NW];
  logic [1:0] ps [NW];
  int first_lo [2];
  int lows     [2];
  int falls    [2];

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      miscompares++;
      $display("FAIL watchdog (R1..all) actual=%0d expected<=100000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_plan();
    for (int i = 0; i < NW; i++) begin
      pb[i] = 2'b11;
      ps[i] = 2'b11;
    end
  endtask

  task automatic set_btn(input int b, input int from, input int to);
    for (int i = from; i < to; i++) pb[i][b] = 1'b0;
  endtask

  task automatic set_sup(input int b, input int from, input int to);
    for (int i = from; i < to; i++) ps[i][b] = 1'b0;
  endtask

  // index 0: dual-mode instance, index 1: single-mode instance
  task automatic run_plan();
    logic [1:0] prev;
    logic [1:0] cur;
    prev = 2'b11;
    for (int k = 0; k < 2; k++) begin
      first_lo[k] = -1; lows[k] = 0; falls[k] = 0;
    end
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      btn = pb[i];
      sup = ps[i];
      cur = {out_s, out_d};
      for (int k = 0; k < 2; k++) begin
        if (!cur[k]) begin
          lows[k]++;
          if (first_lo[k] < 0) first_lo[k] = i;
        end
        if (prev[k] && !cur[k]) falls[k]++;
      end
      prev = cur;
    end
  endtask

  // press model from R3..R8: fires when a run of presses reaches S while armed
  task automatic model(input bit dual, output int fires, output int ff);
    int  run;
    bit  armed;
    bit  pr;
    run = 0; armed = 1'b1; fires = 0; ff = -1;
    for (int i = 0; i < NW; i++) begin
      pr = dual ? (pb[i] == 2'b00) : (pb[i][0] == 1'b0);
      if (pr) begin
        run++;
        if (armed && run >= S) begin
          fires++;
          if (ff < 0) ff = i;
          armed = 1'b0;
        end
      end else begin
        run = 0;
        armed = 1'b1;
      end
    end
  endtask

  task automatic check_manual(input string tag);
    int fires;
    int ff;
    for (int k = 0; k < 2; k++) begin
      model(k == 0, fires, ff);
      chk($sformatf("%s %s falls", tag, k == 0 ? "dual" : "single"), falls[k], fires);
      chk($sformatf("%s %s lows", tag, k == 0 ? "dual" : "single"), lows[k], fires * H);
      if (fires > 0)
        chk($sformatf("%s %s start", tag, k == 0 ? "dual" : "single"), first_lo[k], ff + 3);
    end
  endtask

  initial begin
    int fh [2];
    rst_n = 1'b0;
    sup   = 2'b11;
    btn   = 2'b11;
    clear_plan();
    repeat (3) @(negedge clk);
    chk("R10 reset level dual", int'(out_d), 0);
    chk("R10 reset level single", int'(out_s), 0);
    rst_n = 1'b1;
    fh[0] = -1; fh[1] = -1;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (out_d && fh[0] < 0) fh[0] = i;
      if (out_s && fh[1] < 0) fh[1] = i;
    end
    chk("R10 power-on release dual", fh[0], H + 2);
    chk("R10 power-on release single", fh[1], H + 2);

    // button 0 alone, length sweep across the setup threshold
    for (int L = 1; L <= S + 4; L++) begin
      clear_plan(); set_btn(0, 0, L); run_plan();
      check_manual($sformatf("R3 R4 R8 btn0 len=%0d", L));
    end

    // button 1 alone: single mode ignores it, dual mode needs both
    for (int L = S; L <= S + 4; L += 4) begin
      clear_plan(); set_btn(1, 0, L); run_plan();
      check_manual($sformatf("R8 btn1 len=%0d", L));
    end

    // dual overlap sweep
    for (int k = 0; k < 4; k++) begin
      for (int L = S - 2; L <= S + 1; L++) begin
        clear_plan(); set_btn(0, 0, S + 6); set_btn(1, k, k + L); run_plan();
        check_manual($sformatf("R7 overlap off=%0d len=%0d", k, L));
      end
    end

    // dual restart when one button lifts briefly
    clear_plan(); set_btn(0, 0, 30); set_btn(1, 0, S - 2); set_btn(1, S - 1, 30);
    run_plan(); check_manual("R7 restart");

    // long hold gives a single pulse
    clear_plan(); set_btn(0, 0, 40); set_btn(1, 0, 40);
    run_plan(); check_manual("R5 long hold");

    // re-arm after a one-cycle release
    clear_plan();
    set_btn(0, 0, 12); set_btn(1, 0, 12);
    set_btn(0, 13, 13 + S); set_btn(1, 13, 13 + S);
    run_plan(); check_manual("R6 rearm");

    // supply drop sweep on each flag
    for (int b = 0; b < 2; b++) begin
      for (int F = 1; F <= 6; F++) begin
        clear_plan(); set_sup(b, 2, 2 + F); run_plan();
        for (int k = 0; k < 2; k++) begin
          chk($sformatf("R1 sup%0d F=%0d start k=%0d", b, F, k), first_lo[k], 5);
          chk($sformatf("R2 sup%0d F=%0d lows k=%0d", b, F, k), lows[k], F + H - 1);
          chk($sformatf("R2 sup%0d F=%0d falls k=%0d", b, F, k), falls[k], 1);
        end
      end
    end

    // supply drop during a manual pulse
    clear_plan(); set_btn(0, 0, 50); set_btn(1, 0, 50); set_sup(0, S + 4, S + 6);
    run_plan();
    for (int k = 0; k < 2; k++) begin
      chk($sformatf("R9 falls k=%0d", k), falls[k], 1);
      chk($sformatf("R9 start k=%0d", k), first_lo[k], S + 2);
      chk($sformatf("R9 lows k=%0d", k), lows[k], H + 6);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule